// File: doc/BRIEF.md
# Broadcast Message Store with Mask Interrupt

This block sits behind a timing receiver that delivers decoded broadcast commands, each a sub-address byte with a data byte. Every accepted command writes its data byte into a 256-byte dual-port memory at the location its sub-address selects, so the memory always holds the most recent message of the current turn. A host reads the memory as 32-bit words and reads a small set of registers over a simple single-cycle register interface. At each turn start the block takes a snapshot of a 24-bit turn counter, so the host can tie the memory contents to a turn.

Two sub-address/mask pairs define an interrupt. When a stored command hits a selected sub-address with a data bit in common with that pair's mask, an interrupt request is raised. The rest of the current message is still stored. At the next turn start the memory and the turn snapshot freeze, and they stay frozen until the host has read the last memory word. Three saturating counters tally single-bit, double-bit and transmission errors reported with the commands. Commands that carry a double-bit or transmission error are dropped.

Top module: `msg_store`

## Requirements
- R1: An accepted, stored command writes its data byte to byte location sub-address; host memory word w (word address 0..63) returns byte 4w in bits 7:0, 4w+1 in 15:8, 4w+2 in 23:16 and 4w+3 in 31:24; host writes to word addresses 0..63 have no effect.
- R2: A command with errDouble or errTrans high in the same cycle is not stored; a command with only errSingle high is stored.
- R3: On a turnStart cycle the turnCount value is captured into the snapshot register (word address 66, bits 23:0), except while the memory is frozen or at the turn start that freezes it; reset value 0.
- R4: Control register (word address 64) bit 2 enables storage; while it is 0 no command is stored and none can raise the interrupt. Bit 4 enables the mask interrupt. Both read back at the same positions.
- R5: With bit 4 set, a stored command whose sub-address equals select A (trigger register word 67, bits 7:0) and whose data shares a set bit with mask A (bits 15:8), or equals select B (bits 23:16) sharing a bit with mask B (bits 31:24), sets the interrupt request; irq follows it and status (word 65) bit 6 shows it. Commands at other sub-addresses or without a common bit do not set it.
- R6: The interrupt request stays set until the host writes control with bit 5 = 1, which clears it; bit 5 reads as 0.
- R7: After a hit, later commands before the next turnStart are still stored; from that turnStart on, the memory and the snapshot are frozen (commands in the freezing cycle included) and status bit 5 reads 1.
- R8: A host read of word 63 while frozen ends the freeze; storage and snapshots resume from the next cycle and status bit 5 reads 0.
- R9: Words 68, 69 and 70 hold 16-bit counters of the cycles with errSingle, errDouble and errTrans high; each saturates at 0xFFFF and any host write to it sets it to 0.
- R10: A host read presents its data on hostRdData with hostRdValid high in the cycle after hostRd, and hostRdValid is low otherwise.
- R11: After reset, control, status, trigger, snapshot and counters read 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Decoded command present this cycle |
| cmdSubAddr | input | 8 | Command sub-address |
| cmdData | input | 8 | Command data byte |
| errSingle | input | 1 | Corrected single-bit error strobe |
| errDouble | input | 1 | Double-bit error strobe |
| errTrans | input | 1 | Transmission error strobe |
| turnStart | input | 1 | One-cycle pulse at the start of a turn |
| turnCount | input | 24 | Running turn counter value |
| hostRd | input | 1 | Host read request |
| hostWr | input | 1 | Host write request |
| hostAddr | input | 7 | Host word address |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data |
| hostRdValid | output | 1 | Read data valid |
| irq | output | 1 | Mask interrupt request |

## Verification
The hardest state to reach is a frozen memory holding a message that is partly from before the hit and partly from after it, with the interrupt already cleared but the freeze still in place. The stimulus programs both select/mask pairs, sends near-misses (a selected sub-address without a common bit, a matching bit at an unselected sub-address), then a true hit followed by more commands, a freezing turn start, blocked commands, an interrupt clear and finally the releasing read of the last word. Saturation is reached by holding the single-error strobe high for more than 65,535 cycles.

// File: rtl/msg_store_pkg.sv
package msg_store_pkg;

  // Strobes and state passed from control to datapath
  typedef struct packed {
    logic memWe;    // store the current command
    logic snapEn;   // capture the turn counter
    logic frozen;   // message held for the host
    logic irqPend;  // mask interrupt pending
  } storeCtl_t;

  // Register offsets inside the upper half of the host address space
  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_STAT = 3'd1;
  localparam logic [2:0] REG_SNAP = 3'd2;
  localparam logic [2:0] REG_TRIG = 3'd3;
  localparam logic [2:0] REG_CNT0 = 3'd4;

  localparam int NUM_ERR = 3;

  localparam int CTRL_WEN_BIT  = 2;
  localparam int CTRL_IEN_BIT  = 4;
  localparam int CTRL_CLR_BIT  = 5;
  localparam int STAT_HELD_BIT = 5;
  localparam int STAT_IRQ_BIT  = 6;

endpackage

// File: rtl/msg_store_ram.sv
module msg_store_ram #(
  parameter int SUB_W  = 8,
  parameter int DATA_W = 8,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [SUB_W-1:0]          wrSub,
  input  logic [DATA_W-1:0]         wrData,
  input  logic                      rdEn,
  input  logic [SUB_W-$clog2(LANES)-1:0] rdAddr,
  output logic [LANES*DATA_W-1:0]   rdData
);
  localparam int LANE_W  = $clog2(LANES);
  localparam int WORD_AW = SUB_W - LANE_W;
  localparam int WORDS   = 2 ** WORD_AW;

  logic [LANE_W-1:0]  wrLane;
  logic [WORD_AW-1:0] wrWord;

  assign wrLane = wrSub[LANE_W-1:0];
  assign wrWord = wrSub[SUB_W-1:LANE_W];

  // One byte-wide bank per lane: a single command writes one bank,
  // a host read fetches one byte from every bank at once.
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [DATA_W-1:0] bank [WORDS];
    logic [DATA_W-1:0] laneQ;

    always_ff @(posedge clk) begin
      if (we && wrLane == LANE_W'(g)) bank[wrWord] <= wrData;
      if (rdEn) laneQ <= bank[rdAddr];
    end

    assign rdData[g*DATA_W +: DATA_W] = laneQ;
  end

endmodule

// File: rtl/msg_store_ctrl.sv
module msg_store_ctrl
  import msg_store_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      errDouble,
  input  logic      errTrans,
  input  logic      turnStart,
  input  logic      cfgWriteEn,
  input  logic      cfgIrqEn,
  input  logic      clrIrqStb,
  input  logic      maskHit,
  input  logic      lastWordRd,
  output storeCtl_t ctl
);
  logic armedQ;   // hit seen, freeze at next turn start
  logic frozenQ;
  logic irqQ;
  logic blockNow;
  logic storeOk;
  logic hit;

  always_comb begin
    blockNow = frozenQ || (armedQ && turnStart);
    storeOk  = cmdValid && !errDouble && !errTrans && cfgWriteEn && !blockNow;
    hit      = storeOk && cfgIrqEn && maskHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ  <= 1'b0;
      frozenQ <= 1'b0;
      irqQ    <= 1'b0;
    end else begin
      if (armedQ && turnStart) begin
        frozenQ <= 1'b1;
        armedQ  <= 1'b0;
      end else if (hit) begin
        armedQ  <= 1'b1;
      end
      if (frozenQ && lastWordRd) frozenQ <= 1'b0;
      if (hit) irqQ <= 1'b1;
      else if (clrIrqStb) irqQ <= 1'b0;
    end
  end

  always_comb begin
    ctl.memWe   = storeOk;
    ctl.snapEn  = turnStart && !blockNow;
    ctl.frozen  = frozenQ;
    ctl.irqPend = irqQ;
  end

endmodule

// File: rtl/msg_store_dp.sv
module msg_store_dp
  import msg_store_pkg::*;
#(
  parameter int SUB_W  = 8,
  parameter int DATA_W = 8,
  parameter int TURN_W = 24,
  parameter int CNT_W  = 16,
  parameter int LANES  = 4,
  localparam int LANE_W  = $clog2(LANES),
  localparam int WORD_AW = SUB_W - LANE_W,
  localparam int HOST_AW = WORD_AW + 1,
  localparam int HW      = LANES * DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SUB_W-1:0]   cmdSubAddr,
  input  logic [DATA_W-1:0]  cmdData,
  input  logic               errSingle,
  input  logic               errDouble,
  input  logic               errTrans,
  input  logic [TURN_W-1:0]  turnCount,
  input  logic               hostRd,
  input  logic               hostWr,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [HW-1:0]      hostWrData,
  input  storeCtl_t          ctl,
  output logic               cfgWriteEn,
  output logic               cfgIrqEn,
  output logic               clrIrqStb,
  output logic               maskHit,
  output logic               lastWordRd,
  output logic [HW-1:0]      hostRdData,
  output logic               hostRdValid
);
  logic              isMem;
  logic [2:0]        regIdx;
  logic              regWr;
  logic              wenQ, ienQ;
  logic [SUB_W-1:0]  selAQ, selBQ;
  logic [DATA_W-1:0] maskAQ, maskBQ;
  logic [TURN_W-1:0] snapQ;
  logic [NUM_ERR-1:0] errVec;
  logic [CNT_W-1:0]  errCnt [NUM_ERR];
  logic [HW-1:0]     ramWord;
  logic [HW-1:0]     regRdQ;
  logic              memSelQ;
  logic              rdValidQ;
  logic [HW-1:0]     regMux;

  assign isMem  = !hostAddr[HOST_AW-1];
  assign regIdx = hostAddr[2:0];
  assign regWr  = hostWr && !isMem;
  assign errVec = {errTrans, errDouble, errSingle};

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wenQ   <= 1'b0;
      ienQ   <= 1'b0;
      selAQ  <= '0;
      maskAQ <= '0;
      selBQ  <= '0;
      maskBQ <= '0;
    end else if (regWr) begin
      if (regIdx == REG_CTRL) begin
        wenQ <= hostWrData[CTRL_WEN_BIT];
        ienQ <= hostWrData[CTRL_IEN_BIT];
      end
      if (regIdx == REG_TRIG) begin
        selAQ  <= hostWrData[SUB_W-1:0];
        maskAQ <= hostWrData[SUB_W +: DATA_W];
        selBQ  <= hostWrData[SUB_W+DATA_W +: SUB_W];
        maskBQ <= hostWrData[2*SUB_W+DATA_W +: DATA_W];
      end
    end
  end

  assign cfgWriteEn = wenQ;
  assign cfgIrqEn   = ienQ;
  assign clrIrqStb  = regWr && regIdx == REG_CTRL && hostWrData[CTRL_CLR_BIT];

  // Mask comparison for both trigger pairs
  always_comb begin
    maskHit = ((cmdSubAddr == selAQ) && |(cmdData & maskAQ)) ||
              ((cmdSubAddr == selBQ) && |(cmdData & maskBQ));
  end

  // Turn counter snapshot
  always_ff @(posedge clk) begin
    if (!rstN) snapQ <= '0;
    else if (ctl.snapEn) snapQ <= turnCount;
  end

  // Saturating error counters, cleared by any host write
  for (genvar k = 0; k < NUM_ERR; k++) begin : gErr
    logic clrHit;
    assign clrHit = regWr && regIdx == (REG_CNT0 + 3'(k));
    always_ff @(posedge clk) begin
      if (!rstN || clrHit) errCnt[k] <= '0;
      else if (errVec[k] && errCnt[k] != '1) errCnt[k] <= errCnt[k] + 1'b1;
    end
  end

  // Message memory
  msg_store_ram #(
    .SUB_W (SUB_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) ram_i (
    .clk   (clk),
    .we    (ctl.memWe),
    .wrSub (cmdSubAddr),
    .wrData(cmdData),
    .rdEn  (hostRd && isMem),
    .rdAddr(hostAddr[WORD_AW-1:0]),
    .rdData(ramWord)
  );

  assign lastWordRd = hostRd && isMem && (hostAddr[WORD_AW-1:0] == '1);

  // Register read selection
  always_comb begin
    regMux = '0;
    case (regIdx)
      REG_CTRL: begin
        regMux[CTRL_WEN_BIT] = wenQ;
        regMux[CTRL_IEN_BIT] = ienQ;
      end
      REG_STAT: begin
        regMux[STAT_HELD_BIT] = ctl.frozen;
        regMux[STAT_IRQ_BIT]  = ctl.irqPend;
      end
      REG_SNAP: regMux = HW'(snapQ);
      REG_TRIG: regMux = HW'({maskBQ, selBQ, maskAQ, selAQ});
      default: begin
        for (int k = 0; k < NUM_ERR; k++)
          if (regIdx == REG_CNT0 + 3'(k)) regMux = HW'(errCnt[k]);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdQ   <= '0;
      memSelQ  <= 1'b0;
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= hostRd;
      if (hostRd) begin
        regRdQ  <= regMux;
        memSelQ <= isMem;
      end
    end
  end

  assign hostRdData  = memSelQ ? ramWord : regRdQ;
  assign hostRdValid = rdValidQ;

endmodule

// File: rtl/msg_store.sv
module msg_store
  import msg_store_pkg::*;
#(
  parameter int SUB_W  = 8,
  parameter int DATA_W = 8,
  parameter int TURN_W = 24,
  parameter int CNT_W  = 16,
  parameter int LANES  = 4,
  localparam int WORD_AW = SUB_W - $clog2(LANES),
  localparam int HOST_AW = WORD_AW + 1,
  localparam int HW      = LANES * DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [SUB_W-1:0]   cmdSubAddr,
  input  logic [DATA_W-1:0]  cmdData,
  input  logic               errSingle,
  input  logic               errDouble,
  input  logic               errTrans,
  input  logic               turnStart,
  input  logic [TURN_W-1:0]  turnCount,
  input  logic               hostRd,
  input  logic               hostWr,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [HW-1:0]      hostWrData,
  output logic [HW-1:0]      hostRdData,
  output logic               hostRdValid,
  output logic               irq
);
  storeCtl_t ctl;
  logic cfgWriteEn, cfgIrqEn, clrIrqStb, maskHit, lastWordRd;

  msg_store_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .errDouble (errDouble),
    .errTrans  (errTrans),
    .turnStart (turnStart),
    .cfgWriteEn(cfgWriteEn),
    .cfgIrqEn  (cfgIrqEn),
    .clrIrqStb (clrIrqStb),
    .maskHit   (maskHit),
    .lastWordRd(lastWordRd),
    .ctl       (ctl)
  );

  msg_store_dp #(
    .SUB_W (SUB_W),
    .DATA_W(DATA_W),
    .TURN_W(TURN_W),
    .CNT_W (CNT_W),
    .LANES (LANES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .cmdSubAddr (cmdSubAddr),
    .cmdData    (cmdData),
    .errSingle  (errSingle),
    .errDouble  (errDouble),
    .errTrans   (errTrans),
    .turnCount  (turnCount),
    .hostRd     (hostRd),
    .hostWr     (hostWr),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .ctl        (ctl),
    .cfgWriteEn (cfgWriteEn),
    .cfgIrqEn   (cfgIrqEn),
    .clrIrqStb  (clrIrqStb),
    .maskHit    (maskHit),
    .lastWordRd (lastWordRd),
    .hostRdData (hostRdData),
    .hostRdValid(hostRdValid)
  );

  assign irq = ctl.irqPend;

endmodule

// File: rtl/msg_store_chk.sv
module msg_store_chk
  import msg_store_pkg::*;
#(
  parameter int HOST_AW = 7,
  parameter int HW      = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               cmdValid,
  input logic               errDouble,
  input logic               errTrans,
  input logic               hostRd,
  input logic               hostWr,
  input logic [HOST_AW-1:0] hostAddr,
  input logic [HW-1:0]      hostWrData,
  input logic               hostRdValid,
  input logic               irq,
  input storeCtl_t          ctl
);
  localparam logic [HOST_AW-1:0] LAST_WORD = {1'b0, {(HOST_AW-1){1'b1}}};
  localparam logic [HOST_AW-1:0] CTRL_ADDR = {1'b1, {(HOST_AW-1){1'b0}}};

  logic releaseRd;
  logic clrWr;
  assign releaseRd = hostRd && hostAddr == LAST_WORD;
  assign clrWr     = hostWr && hostAddr == CTRL_ADDR && hostWrData[CTRL_CLR_BIT];

  // R2: commands with uncorrectable errors never reach the memory
  a_r2_reject_bad: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (errDouble || errTrans)) |-> !ctl.memWe);

  // R7: a frozen memory takes no writes and no snapshots
  a_r7_frozen_no_write: assert property (@(posedge clk) disable iff (!rstN)
    ctl.frozen |-> (!ctl.memWe && !ctl.snapEn));

  // R8: only the read of the last word ends a freeze
  a_r8_freeze_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.frozen && !releaseRd) |=> ctl.frozen);

  // R6: the interrupt stays until the host clears it
  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !clrWr) |=> irq);

  // R10: read data valid exactly one cycle after a read
  a_r10_rd_valid: assert property (@(posedge clk) disable iff (!rstN)
    hostRd |=> hostRdValid);
  a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !hostRd |=> !hostRdValid);

endmodule

bind msg_store msg_store_chk #(
  .HOST_AW(HOST_AW),
  .HW     (HW)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .errDouble  (errDouble),
  .errTrans   (errTrans),
  .hostRd     (hostRd),
  .hostWr     (hostWr),
  .hostAddr   (hostAddr),
  .hostWrData (hostWrData),
  .hostRdValid(hostRdValid),
  .irq        (irq),
  .ctl        (ctl)
);

// File: tb/msg_store_tb.sv
module msg_store_tb_top;
  localparam int CLK_PERIOD = 10;

  localparam logic [6:0] A_CTRL = 7'd64;
  localparam logic [6:0] A_STAT = 7'd65;
  localparam logic [6:0] A_SNAP = 7'd66;
  localparam logic [6:0] A_TRIG = 7'd67;
  localparam logic [6:0] A_CNTS = 7'd68;
  localparam logic [6:0] A_CNTD = 7'd69;
  localparam logic [6:0] A_CNTT = 7'd70;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [7:0]  cmdSubAddr = '0;
  logic [7:0]  cmdData = '0;
  logic        errSingle = 1'b0, errDouble = 1'b0, errTrans = 1'b0;
  logic        turnStart = 1'b0;
  logic [23:0] turnCount = '0;
  logic        hostRd = 1'b0, hostWr = 1'b0;
  logic [6:0]  hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        hostRdValid;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [31:0] expQ [$];
  bit          dcQ  [$];
  string       tagQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_store dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdSubAddr(cmdSubAddr),
    .cmdData(cmdData), .errSingle(errSingle), .errDouble(errDouble),
    .errTrans(errTrans), .turnStart(turnStart), .turnCount(turnCount),
    .hostRd(hostRd), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .hostRdValid(hostRdValid), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expectation per returned read
  always @(negedge clk) begin
    if (rstN && hostRdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected read data", hostRdData, 32'h0);
      end else begin
        logic [31:0] e;
        bit d;
        string t;
        e = expQ.pop_front();
        d = dcQ.pop_front();
        t = tagQ.pop_front();
        if (!d) check(hostRdData === e, t, hostRdData, e);
      end
    end
  end

  task automatic hostRead(input logic [6:0] a, input logic [31:0] e,
                          input bit dc, input string t);
    expQ.push_back(e);
    dcQ.push_back(dc);
    tagQ.push_back(t);
    hostRd = 1'b1; hostAddr = a;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic hostWrite(input logic [6:0] a, input logic [31:0] d);
    hostWr = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic sendCmd(input logic [7:0] s, input logic [7:0] d,
                         input bit es, input bit ed, input bit et);
    cmdValid = 1'b1; cmdSubAddr = s; cmdData = d;
    errSingle = es; errDouble = ed; errTrans = et;
    @(negedge clk);
    cmdValid = 1'b0; errSingle = 1'b0; errDouble = 1'b0; errTrans = 1'b0;
  endtask

  task automatic pulseTurn(input logic [23:0] c);
    turnStart = 1'b1; turnCount = c;
    @(negedge clk);
    turnStart = 1'b0;
  endtask

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      check(1'b0, "watchdog expired", 32'h0, 32'h1);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11: reset state
    check(irq == 1'b0, "R11 irq after reset", {31'b0, irq}, 32'h0);
    check(hostRdValid == 1'b0, "R10 no valid when idle", {31'b0, hostRdValid}, 32'h0);
    hostRead(A_CTRL, 32'h0, 0, "R11 control reset");
    hostRead(A_STAT, 32'h0, 0, "R11 status reset");
    hostRead(A_SNAP, 32'h0, 0, "R11 snapshot reset");
    hostRead(A_CNTS, 32'h0, 0, "R11 counter reset");

    // Configure: store + mask interrupt; A = 0x15/0x01, B = 0x20/0x80
    hostWrite(A_CTRL, 32'h14);
    hostWrite(A_TRIG, 32'h8020_0115);
    hostRead(A_CTRL, 32'h14, 0, "R4 control readback");
    hostRead(A_TRIG, 32'h8020_0115, 0, "R5 trigger readback");

    // R1/R3: one message with snapshot
    pulseTurn(24'h123456);
    for (int i = 0; i < 8; i++) sendCmd(8'(i), 8'(8'hA0 + i), 0, 0, 0);
    hostRead(7'd0, 32'hA3A2_A1A0, 0, "R1 word 0 packing");
    hostRead(7'd1, 32'hA7A6_A5A4, 0, "R1 word 1 packing");
    hostRead(A_SNAP, 32'h0012_3456, 0, "R3 snapshot capture");

    // R2: error handling
    sendCmd(8'd0, 8'h55, 0, 1, 0);
    sendCmd(8'd1, 8'h66, 0, 0, 1);
    sendCmd(8'd2, 8'h77, 1, 0, 0);
    hostRead(7'd0, 32'hA377_A1A0, 0, "R2 rejected and corrected");

    // R1: host write to memory ignored
    hostWrite(7'd0, 32'hDEAD_BEEF);
    hostRead(7'd0, 32'hA377_A1A0, 0, "R1 memory write ignored");

    // R4: storage disabled
    hostWrite(A_CTRL, 32'h10);
    sendCmd(8'd3, 8'h11, 0, 0, 0);
    sendCmd(8'h20, 8'h80, 0, 0, 0);
    check(irq == 1'b0, "R4 no irq while storage off", {31'b0, irq}, 32'h0);
    hostWrite(A_CTRL, 32'h14);
    hostRead(7'd0, 32'hA377_A1A0, 0, "R4 no store while disabled");

    // R5: near misses
    sendCmd(8'h15, 8'hFE, 0, 0, 0);
    sendCmd(8'h20, 8'h7F, 0, 0, 0);
    sendCmd(8'h16, 8'h01, 0, 0, 0);
    check(irq == 1'b0, "R5 no irq on near misses", {31'b0, irq}, 32'h0);

    // R5/R7: hit, then more of the same message, then freeze
    sendCmd(8'h20, 8'h80, 0, 0, 0);
    check(irq == 1'b1, "R5 irq on mask hit", {31'b0, irq}, 32'h1);
    hostRead(A_STAT, 32'h40, 0, "R5 status irq bit");
    sendCmd(8'd4, 8'hB4, 0, 0, 0);
    pulseTurn(24'h000777);
    sendCmd(8'd5, 8'hC5, 0, 0, 0);
    hostRead(A_STAT, 32'h60, 0, "R7 status frozen");
    hostRead(7'd1, 32'hA7A6_A5B4, 0, "R7 rest of message kept, later blocked");
    hostRead(A_SNAP, 32'h0012_3456, 0, "R3 snapshot held while frozen");

    // R6: clear interrupt, freeze remains
    hostWrite(A_CTRL, 32'h34);
    check(irq == 1'b0, "R6 irq cleared", {31'b0, irq}, 32'h0);
    hostRead(A_CTRL, 32'h14, 0, "R6 clear bit reads zero");
    sendCmd(8'd5, 8'hD5, 0, 0, 0);
    hostRead(A_STAT, 32'h20, 0, "R6 freeze outlives clear");

    // R8: release by reading last word
    hostRead(7'd63, 32'h0, 1, "R8 last word");
    hostRead(A_STAT, 32'h0, 0, "R8 status released");
    sendCmd(8'd5, 8'hE5, 0, 0, 0);
    hostRead(7'd1, 32'hA7A6_E5B4, 0, "R8 storage resumes");
    pulseTurn(24'h000888);
    hostRead(A_SNAP, 32'h0000_0888, 0, "R8 snapshot resumes");

    // R9: counters, saturation and clear
    hostRead(A_CNTD, 32'h1, 0, "R9 double counter");
    hostRead(A_CNTT, 32'h1, 0, "R9 transmission counter");
    errSingle = 1'b1;
    repeat (65540) @(negedge clk);
    errSingle = 1'b0;
    hostRead(A_CNTS, 32'h0000_FFFF, 0, "R9 saturation");
    hostWrite(A_CNTS, 32'h1234);
    hostRead(A_CNTS, 32'h0, 0, "R9 clear on write");
    hostRead(A_CNTD, 32'h1, 0, "R9 other counter untouched");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R10 all reads returned", 32'(expQ.size()), 32'h0);
    done = 1'b1;
    finishRun();
  end

endmodule